// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four Static Memory Port Model

This block is a synthesizable cycle model of a static memory with two independent data ports: a read port with its own output bus and a write port with its own input bus. Neither bus ever changes direction. One address input serves both ports. The block runs on a single clock at twice the command rate. A phase bit, brought out as `k_half`, marks each rising edge as either a command edge (K) or an intermediate edge (K-bar). Every address names a row of four data words, and these words move as a burst, one word per rising edge.

A read request is taken on a K edge, with its address on the shared bus at that same edge. The four words of the row then leave on consecutive edges after a latency that `dll_mode` selects. A write request is also taken on a K edge. Its address and first word arrive on the next edge, a K-bar edge, and the remaining three words follow on the next three edges. The collected burst waits in a one-entry buffer and is committed to the array one edge after its last word. Reads see the newest data word by word, whether that data is still in the buffer or already in the array.

The design is built from three state machines:
- **Read-request timer.** States RQ_IDLE, RQ_WAIT2, RQ_WAIT1 and RQ_LAUNCH. RQ_IDLE goes to RQ_WAIT2 on a slow-mode accept or to RQ_WAIT1 on a fast-mode accept. The chain then steps RQ_WAIT2 to RQ_WAIT1, RQ_WAIT1 to RQ_LAUNCH, and RQ_LAUNCH back to RQ_IDLE.
- **Output sequencer.** States OUT_IDLE, OUT_BEAT1, OUT_BEAT2 and OUT_BEAT3. A launch moves it from OUT_IDLE to OUT_BEAT1 while word 0 is driven. It then steps OUT_BEAT1 to OUT_BEAT2 and OUT_BEAT2 to OUT_BEAT3. From OUT_BEAT3 it returns to OUT_IDLE, or goes to OUT_BEAT1 if a new launch arrives.
- **Write collector.** States WR_IDLE, WR_ADDR, WR_BEAT1, WR_BEAT2 and WR_BEAT3. An accept moves it from WR_IDLE to WR_ADDR. It then steps WR_ADDR to WR_BEAT1, WR_BEAT1 to WR_BEAT2 and WR_BEAT2 to WR_BEAT3. From WR_BEAT3 it goes to WR_ADDR on a new accept, otherwise to WR_IDLE.

Top module: `qdr_b4_sram`

## Requirements
- R1: Reset state.
  - While `rst_n` is low and after its release, `rdata_vld`, `rdata` and `k_half` are 0.
  - Every word of every row reads as zero until it is written.
- R2: `k_half` inverts on every rising clock edge after reset. A value of 0 means the coming rising edge is a K edge, and a value of 1 means it is a K-bar edge.
- R3: Read burst.
  - A read is requested by `rd_req_n` low on a K edge, with the row address taken from `addr` at that same edge.
  - Words 0, 1, 2 and 3 of that row are driven on four consecutive edges.
  - `rdata_vld` is high exactly while a burst word is on `rdata`, and `rdata` is zero whenever `rdata_vld` is low.
- R4: Read latency.
  - With `dll_mode` = 1, the first word is registered at the third edge after the request edge (1.5 cycles).
  - With `dll_mode` = 0, it is registered at the second edge (1 cycle).
  - `dll_mode` is sampled on the request edge.
- R5: Write burst.
  - A write is requested by `wr_req_n` low on a K edge.
  - On the next edge (K-bar), `addr` gives the row and `wdata` gives word 0.
  - `wdata` gives words 1, 2 and 3 on the three edges after that.
- R6: Coherence. A read word driven at an edge returns the value of the last write word to that row and word that was captured at an earlier edge, including words still held in the write buffer.
- R7: `rd_req_n` and `wr_req_n` have no effect on K-bar edges.
- R8: Busy ports ignore requests.
  - A read request on the K edge right after an accepted read is ignored.
  - A write request on the K edge during a burst's collection is ignored, except on the edge that captures word 3.
- R9: A read and a write requested on the same K edge are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each rising edge is a K or K-bar edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dll_mode | input | 1 | Read latency select: 1 gives 1.5 cycles, 0 gives 1 cycle |
| rd_req_n | input | 1 | Active-low read port select, sampled on K edges |
| wr_req_n | input | 1 | Active-low write port select, sampled on K edges |
| addr | input | ADDR_W | Shared address: read row on K edges, write row on K-bar edges |
| wdata | input | DATA_W | Write data, one word per edge |
| k_half | output | 1 | Phase of the coming edge: 0 = K, 1 = K-bar |
| rdata | output | DATA_W | Read data, one word per edge |
| rdata_vld | output | 1 | High while a read burst word is on `rdata` |

## Verification
A directed pass reads every row before any write, which separates a correctly cleared array from stale contents. Further directed patterns each target one behaviour:
- a read issued while a write to the same row is still collecting, which separates buffer forwarding from array-only reads;
- a read and a write on one K edge, which shows that both ports are accepted together;
- selects asserted only on K-bar edges, which should produce nothing;
- selects asserted on every K edge, which exposes any missing busy blocking.

Random traffic then runs under both latency settings with addresses crowded onto a few rows, so that read and write hits happen often. This separates 1-cycle timing from 1.5-cycle timing and tests ordering between writes that land back to back.

// File: rtl/qdr_b4_pkg.sv
package qdr_b4_pkg;

    // Words per row; the burst sequencing below assumes four beats.
    localparam int unsigned BEATS  = 4;
    localparam int unsigned BEAT_W = $clog2(BEATS);

    // Read-request timer: counts the latency from request to first word.
    typedef enum logic [1:0] {
        RQ_IDLE,
        RQ_WAIT2,
        RQ_WAIT1,
        RQ_LAUNCH
    } rq_state_e;

    // Output sequencer: which beat is driven at the next edge.
    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_BEAT1,
        OUT_BEAT2,
        OUT_BEAT3
    } out_state_e;

    // Write collector: which beat is captured at the next edge.
    typedef enum logic [2:0] {
        WR_IDLE,
        WR_ADDR,
        WR_BEAT1,
        WR_BEAT2,
        WR_BEAT3
    } wr_state_e;

endpackage

// File: rtl/qdr_b4_rd_req.sv
module qdr_b4_rd_req
    import qdr_b4_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_edge,
    input  logic              req_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dll_mode,
    output logic              acc,
    output logic              fire,
    output logic [ADDR_W-1:0] fire_addr
);

    rq_state_e         st, st_nx;
    logic [ADDR_W-1:0] hold_addr;

    // A request is taken only on a K edge and only when no read is pending.
    always_comb begin
        acc   = k_edge && !req_n && (st == RQ_IDLE);
        st_nx = st;
        unique case (st)
            RQ_IDLE:   if (acc) st_nx = dll_mode ? RQ_WAIT2 : RQ_WAIT1;
            RQ_WAIT2:  st_nx = RQ_WAIT1;
            RQ_WAIT1:  st_nx = RQ_LAUNCH;
            RQ_LAUNCH: st_nx = RQ_IDLE;
            default:   st_nx = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RQ_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   hold_addr <= '0;
        else if (acc) hold_addr <= addr;
    end

    assign fire      = (st == RQ_LAUNCH);
    assign fire_addr = hold_addr;

endmodule

// File: rtl/qdr_b4_rd_out.sv
module qdr_b4_rd_out
    import qdr_b4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] fire_addr,
    output logic [ADDR_W-1:0] lk_addr,
    output logic [BEAT_W-1:0] lk_idx,
    input  logic [DATA_W-1:0] lk_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    out_state_e        st, st_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic              drive;

    always_comb begin
        st_nx   = st;
        lk_idx  = '0;
        lk_addr = cur_addr;
        unique case (st)
            OUT_IDLE:  st_nx = OUT_IDLE;
            OUT_BEAT1: begin lk_idx = BEAT_W'(1); st_nx = OUT_BEAT2; end
            OUT_BEAT2: begin lk_idx = BEAT_W'(2); st_nx = OUT_BEAT3; end
            OUT_BEAT3: begin lk_idx = BEAT_W'(3); st_nx = OUT_IDLE;  end
            default:   st_nx = OUT_IDLE;
        endcase
        // A launch always begins a fresh burst at word 0.
        if (fire) begin
            lk_idx  = '0;
            lk_addr = fire_addr;
            st_nx   = OUT_BEAT1;
        end
        drive = fire || (st != OUT_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= OUT_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            if (fire) cur_addr <= fire_addr;
            rdata     <= drive ? lk_data : '0;
            rdata_vld <= drive;
        end
    end

endmodule

// File: rtl/qdr_b4_wr_col.sv
module qdr_b4_wr_col
    import qdr_b4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         k_edge,
    input  logic                         req_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic                         acc,
    output logic [ADDR_W-1:0]            buf_addr,
    output logic [BEATS-1:0][DATA_W-1:0] buf_data,
    output logic [BEATS-1:0]             buf_val,
    output logic                         commit
);

    wr_state_e         st, st_nx;
    logic              cap_en;
    logic [BEAT_W-1:0] slot;

    always_comb begin
        acc    = k_edge && !req_n && ((st == WR_IDLE) || (st == WR_BEAT3));
        st_nx  = st;
        cap_en = 1'b1;
        slot   = '0;
        unique case (st)
            WR_IDLE:  begin cap_en = 1'b0; if (acc) st_nx = WR_ADDR; end
            WR_ADDR:  begin slot = BEAT_W'(0); st_nx = WR_BEAT1; end
            WR_BEAT1: begin slot = BEAT_W'(1); st_nx = WR_BEAT2; end
            WR_BEAT2: begin slot = BEAT_W'(2); st_nx = WR_BEAT3; end
            WR_BEAT3: begin slot = BEAT_W'(3); st_nx = acc ? WR_ADDR : WR_IDLE; end
            default:  begin cap_en = 1'b0; st_nx = WR_IDLE; end
        endcase
        // A full buffer is written into the array at the next edge.
        commit = &buf_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= WR_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr <= '0;
            buf_data <= '0;
            buf_val  <= '0;
        end else begin
            if (cap_en) buf_data[slot] <= wdata;
            if (st == WR_ADDR) begin
                buf_addr <= addr;
                buf_val  <= BEATS'(1);
            end else if (cap_en) begin
                buf_val[slot] <= 1'b1;
            end else if (commit) begin
                buf_val <= '0;
            end
        end
    end

endmodule

// File: rtl/qdr_b4_array.sv
module qdr_b4_array
    import qdr_b4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmt_en,
    input  logic [ADDR_W-1:0]            buf_addr,
    input  logic [BEATS-1:0][DATA_W-1:0] buf_data,
    input  logic [BEATS-1:0]             buf_val,
    input  logic [ADDR_W-1:0]            lk_addr,
    input  logic [BEAT_W-1:0]            lk_idx,
    output logic [DATA_W-1:0]            lk_data
);

    localparam int ROWS = 1 << ADDR_W;

    logic [BEATS-1:0][DATA_W-1:0] mem [ROWS];
    logic [BEATS-1:0]             beat_hit;
    logic                         row_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (cmt_en) begin
            mem[buf_addr] <= buf_data;
        end
    end

    assign row_match = (buf_addr == lk_addr);

    // Per-beat forwarding from the pending burst.
    for (genvar b = 0; b < BEATS; b++) begin : g_hit
        assign beat_hit[b] = buf_val[b] && row_match;
    end

    always_comb begin
        if (beat_hit[lk_idx]) lk_data = buf_data[lk_idx];
        else                  lk_data = mem[lk_addr][lk_idx];
    end

endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram
    import qdr_b4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dll_mode,
    input  logic              rd_req_n,
    input  logic              wr_req_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              k_half,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    logic                         k_edge;
    logic                         rd_acc;
    logic                         wr_acc;
    logic                         fire;
    logic [ADDR_W-1:0]            fire_addr;
    logic [ADDR_W-1:0]            lk_addr;
    logic [BEAT_W-1:0]            lk_idx;
    logic [DATA_W-1:0]            lk_data;
    logic [ADDR_W-1:0]            buf_addr;
    logic [BEATS-1:0][DATA_W-1:0] buf_data;
    logic [BEATS-1:0]             buf_val;
    logic                         commit;

    // Half-cycle phase: 0 before a K edge, 1 before a K-bar edge.
    always_ff @(posedge clk) begin
        if (!rst_n) k_half <= 1'b0;
        else        k_half <= ~k_half;
    end

    assign k_edge = ~k_half;

    qdr_b4_rd_req #(.ADDR_W(ADDR_W)) u_rd_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .k_edge    (k_edge),
        .req_n     (rd_req_n),
        .addr      (addr),
        .dll_mode  (dll_mode),
        .acc       (rd_acc),
        .fire      (fire),
        .fire_addr (fire_addr)
    );

    qdr_b4_rd_out #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .fire_addr (fire_addr),
        .lk_addr   (lk_addr),
        .lk_idx    (lk_idx),
        .lk_data   (lk_data),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    qdr_b4_wr_col #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .k_edge   (k_edge),
        .req_n    (wr_req_n),
        .addr     (addr),
        .wdata    (wdata),
        .acc      (wr_acc),
        .buf_addr (buf_addr),
        .buf_data (buf_data),
        .buf_val  (buf_val),
        .commit   (commit)
    );

    qdr_b4_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmt_en   (commit),
        .buf_addr (buf_addr),
        .buf_data (buf_data),
        .buf_val  (buf_val),
        .lk_addr  (lk_addr),
        .lk_idx   (lk_idx),
        .lk_data  (lk_data)
    );

endmodule

// File: rtl/qdr_b4_sram_chk.sv
module qdr_b4_sram_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              k_half,
    input logic              dll_mode,
    input logic              rd_acc,
    input logic              wr_acc,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_vld
);

    logic live;

    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R3: no data on the read bus outside a burst
    p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_vld |-> (rdata == '0));

    // R3: each burst keeps valid high for four edges
    p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $rose(rdata_vld)) |=> rdata_vld ##1 rdata_vld ##1 rdata_vld);

    // R2: phase inverts on every edge
    p_phase_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (k_half != $past(k_half)));

    // R4: slow mode, valid seen four sampled edges later
    p_lat_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && dll_mode) |-> ##4 rdata_vld);

    // R4: fast mode, valid seen three sampled edges later
    p_lat_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !dll_mode) |-> ##3 rdata_vld);

    // R7: requests are taken only on K edges
    p_kedge_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc || wr_acc) |-> !k_half);

    // R8: no read taken on the K edge after an accepted read
    p_rd_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> ##1 !rd_acc);

    // R8: no write taken on the K edge after an accepted write
    p_wr_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> ##1 !wr_acc);

endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .k_half    (k_half),
    .dll_mode  (dll_mode),
    .rd_acc    (rd_acc),
    .wr_acc    (wr_acc),
    .rdata     (rdata),
    .rdata_vld (rdata_vld)
);

// File: tb/qdr_b4_sram_test.sv
module qdr_b4_sram_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int AW         = 4;
    localparam int NWORDS     = (1 << AW) * 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dll_mode;
    logic          rd_req_n;
    logic          wr_req_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          k_half;
    logic [DW-1:0] rdata;
    logic          rdata_vld;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state, built from the requirements only
    logic [DW-1:0] ref_mem [NWORDS];
    bit            sched_v [16];
    int            sched_a [16];
    int            sched_i [16];
    int            edge_n;
    int            rlast;
    int            wcnt;
    int            waddr;
    logic          exp_vld;
    logic [DW-1:0] exp_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qdr_b4_sram #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dll_mode  (dll_mode),
        .rd_req_n  (rd_req_n),
        .wr_req_n  (wr_req_n),
        .addr      (addr),
        .wdata     (wdata),
        .k_half    (k_half),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    // One rising edge of the reference model, using the held inputs.
    task automatic model_edge();
        int  slot;
        bit  kedge;
        int  lat;
        int  idx;
        slot  = edge_n % 16;
        kedge = (edge_n % 2) == 0;
        // output word registered at this edge sees writes from earlier edges (R6)
        if (sched_v[slot]) begin
            exp_vld       = 1'b1;
            exp_data      = ref_mem[sched_a[slot] * 4 + sched_i[slot]];
            sched_v[slot] = 0;
        end else begin
            exp_vld  = 1'b0;
            exp_data = '0;
        end
        // read accept (R3 R4 R8)
        if (kedge && !rd_req_n && (edge_n - rlast != 2)) begin
            lat = dll_mode ? 3 : 2;
            for (int k = 0; k < 4; k++) begin
                sched_v[(edge_n + lat + k) % 16] = 1;
                sched_a[(edge_n + lat + k) % 16] = int'(addr);
                sched_i[(edge_n + lat + k) % 16] = k;
            end
            rlast = edge_n;
        end
        // write word capture (R5)
        if (wcnt > 0) begin
            idx = 4 - wcnt;
            if (idx == 0) waddr = int'(addr);
            ref_mem[waddr * 4 + idx] = wdata;
            wcnt--;
        end
        // write accept (R5 R8 R9)
        if (kedge && !wr_req_n && wcnt == 0) wcnt = 4;
        edge_n++;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_vec++;
        if (rdata_vld !== exp_vld || rdata !== exp_data) begin
            n_fail++;
            $display("FAIL %s edge %0d: vld/data actual %b/%h expected %b/%h",
                     tag, edge_n, rdata_vld, rdata, exp_vld, exp_data);
        end
        if (k_half !== logic'(edge_n % 2)) begin
            n_fail++;
            $display("FAIL R2 edge %0d: k_half actual %b expected %b",
                     edge_n, k_half, edge_n % 2);
        end
    endtask

    task automatic apply(input logic rd, input logic wr, input int a,
                         input int d, input string tag);
        rd_req_n = rd;
        wr_req_n = wr;
        addr     = AW'(a);
        wdata    = DW'(d);
        step(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) apply(1'b1, 1'b1, $urandom, $urandom, tag);
    endtask

    task automatic sync_k(input string tag);
        if (edge_n % 2 == 1) idle(1, tag);
    endtask

    task automatic rand_run(input int n, input int wr_pct, input string tag);
        for (int i = 0; i < n; i++) begin
            logic rd;
            logic wr;
            int   a;
            rd = (($urandom % 100) >= 45);
            wr = (($urandom % 100) >= wr_pct);
            a  = (($urandom % 4) == 0) ? int'($urandom % (1 << AW)) : int'($urandom % 3);
            apply(rd, wr, a, $urandom, tag);
        end
        idle(10, tag);
    endtask

    initial begin
        void'($urandom(32'h51A7));
        for (int i = 0; i < NWORDS; i++) ref_mem[i] = '0;
        for (int i = 0; i < 16; i++) sched_v[i] = 0;
        edge_n   = 0;
        rlast    = -100;
        wcnt     = 0;
        waddr    = 0;
        rst_n    = 1'b0;
        dll_mode = 1'b1;
        rd_req_n = 1'b1;
        wr_req_n = 1'b1;
        addr     = '0;
        wdata    = '0;
        repeat (4) @(negedge clk);
        // R1: outputs idle during reset
        n_vec++;
        if (rdata_vld !== 1'b0 || rdata !== '0 || k_half !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 in reset: vld/data/k_half actual %b/%h/%b expected 0/00/0",
                     rdata_vld, rdata, k_half);
        end
        rst_n = 1'b1;
        // R1: every row reads zero before any write
        for (int r = 0; r < (1 << AW); r++) begin
            apply(1'b0, 1'b1, r, 0, "R1");
            idle(1, "R1");
        end
        idle(8, "R1");

        // R6: read of a row whose write burst is still being collected
        dll_mode = 1'b0;
        idle(8, "R6");
        sync_k("R6");
        apply(1'b1, 1'b0, 0, 0, "R6");
        apply(1'b1, 1'b1, 5, 8'hA0, "R6");
        apply(1'b0, 1'b1, 5, 8'hA1, "R6");
        apply(1'b1, 1'b1, 0, 8'hA2, "R6");
        apply(1'b1, 1'b1, 0, 8'hA3, "R6");
        idle(8, "R6");

        // R9: read and write on the same K edge
        dll_mode = 1'b1;
        idle(8, "R9");
        sync_k("R9");
        apply(1'b0, 1'b0, 5, 0, "R9");
        apply(1'b1, 1'b1, 9, 8'h91, "R9");
        apply(1'b1, 1'b1, 0, 8'h92, "R9");
        apply(1'b1, 1'b1, 0, 8'h93, "R9");
        apply(1'b0, 1'b1, 9, 8'h94, "R9");
        idle(10, "R9");

        // R7: selects asserted only on K-bar edges do nothing
        sync_k("R7");
        for (int i = 0; i < 20; i++) begin
            if (edge_n % 2 == 1) apply(1'b0, 1'b0, 9, 8'hEE, "R7");
            else                 apply(1'b1, 1'b1, 9, 8'hEE, "R7");
        end
        sync_k("R7");
        apply(1'b0, 1'b1, 9, 0, "R7");
        idle(10, "R7");

        // R8: selects held low on every K edge
        sync_k("R8");
        for (int i = 0; i < 24; i++) apply(1'b0, 1'b0, i % 3, 8'h40 + i, "R8");
        idle(10, "R8");

        // R3 R4 R5: random traffic in both latency modes
        rand_run(3000, 50, "R3");
        dll_mode = 1'b0;
        idle(10, "R4");
        rand_run(3000, 50, "R4");
        dll_mode = 1'b1;
        idle(10, "R5");
        rand_run(2000, 15, "R5");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog: actual run unfinished expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule